// File: doc/BRIEF.md
# Calendar Time Counter with BCD/Binary and 12/24-Hour Modes

This block keeps the time of day and the calendar date. A once-per-second tick advances a chain of fields: seconds, minutes, hours, day of week, day of month, month, two-digit year and a century count. Each carry into the next field follows the field's own limit. Day-of-month limits follow the month length, and February gets a 29th day in years divisible by four.

Software uses a small register port, with a write port and a combinational read port, to see each field. A control register selects how the fields look on that port: packed BCD or plain binary, and a 24-hour clock or a 12-hour clock with a PM flag. The same control register has a freeze bit. Setting it stops the tick and opens the time fields to writes, so a new time can be loaded without a carry arriving partway through. A busy output marks the cycle in which an accepted tick is being applied.

Top module: `caltime_counter`

## Requirements
- R1: After reset the clock reads 00:00:00 in 24-hour BCD form. Day of week, day of month and month read 01. Year and century read 00. The control register reads 0x02.
- R2: With the freeze bit clear, each accepted tick adds one second. Seconds roll 59 to 0 and carry into minutes. Minutes roll 59 to 0 and carry into hours. Hours roll 23 to 0 and carry into the date fields.
- R3: On a day carry, day of week goes from 7 to 1. Day of month goes back to 1 and carries into the month after day 30 in months 4, 6, 9 and 11, after day 28 in February (29 when year mod 4 is 0), and after day 31 otherwise. Month goes from 12 to 1 and carries into the year.
- R4: Year rolls from 99 to 00 and carries into the century. Century rolls from 99 to 00.
- R5: Control bit 2 selects the data form of every field on both reads and writes: 0 is packed BCD, 1 is binary. Changing the bit keeps the stored values and changes only how they appear.
- R6: Control bit 1 selects the hour form: 1 is 24-hour (0 to 23), 0 is 12-hour (1 to 12, with bit 7 of the hours field set for PM). In 12-hour form, 11 PM is followed by 12 AM and then 1 AM, and 11 AM is followed by 12 PM.
- R7: Control bit 7 is the freeze bit. While it is 1, ticks are ignored and writes to time fields take effect. While it is 0, writes to time fields are ignored. The control register can be written at any time.
- R8: A write first clears the field's unused upper bits. BCD masks are: seconds/minutes 0x7F, 24-hour hours 0x3F, 12-hour hours 0x1F, day of month 0x3F, month 0x1F, year 0xFF. Binary masks are: 0x3F, 0x1F, 0x0F, 0x1F, 0x0F and 0x7F in the same order. Day of week uses 0x07 and century uses 0xFF in both forms. A write whose decoded value is outside the field's range is ignored.
- R9: Busy is high in exactly the cycle after a tick is sampled with the freeze bit clear. During that cycle the fields still show their old values. The new values appear in the following cycle.
- R10: The field addresses are: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century, 8 control. The control register reads back with bit 7 freeze, bit 2 binary, bit 1 24-hour, and the other bits 0. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data, in the selected form |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data, in the selected form (combinational) |
| busy | output | 1 | Tick being applied this cycle |

## Verification
The hardest cases to reach are the long carries: a single tick that rolls every field at once, up to the century, and the month-end cases that depend on the year. Counting through these one tick at a time would take years of ticks. The stimulus instead sets the freeze bit, writes a time one second before the boundary of interest, clears the freeze bit and issues one tick. The 12-hour AM/PM changes and the February limits in leap and non-leap years are reached the same way.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC  = 4'd0,
        A_MIN  = 4'd1,
        A_HOUR = 4'd2,
        A_WDAY = 4'd3,
        A_MDAY = 4'd4,
        A_MON  = 4'd5,
        A_YEAR = 4'd6,
        A_CENT = 4'd7,
        A_CTL  = 4'd8
    } fld_e;

    // Control register bit positions
    localparam int CB_FREEZE = 7;
    localparam int CB_BIN    = 2;
    localparam int CB_H24    = 1;

    // All fields are kept in plain binary; the port converts them.
    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;   // always 0..23
        logic [2:0] wday;
        logic [4:0] mday;
        logic [3:0] month;
        logic [6:0] year;
        logic [6:0] cent;
    } cal_t;

    localparam cal_t RESET_CAL = '{sec: 6'd0, min: 6'd0, hour: 5'd0, wday: 3'd1,
                                   mday: 5'd1, month: 4'd1, year: 7'd0, cent: 7'd0};

    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    function automatic logic [7:0] from_bcd(input logic [7:0] b);
        return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
    endfunction

    function automatic logic [7:0] encode(input logic [6:0] v, input logic bin);
        return bin ? {1'b0, v} : to_bcd(v);
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] m, input logic [6:0] y);
        case (m)
            4'd2:                     return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
            default:                  return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/caltime_strobe.sv
module caltime_strobe (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic freeze,
    output logic busy
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= tick && !freeze;
    end

    assign busy = pend_q;
endmodule

// File: rtl/caltime_chain.sv
module caltime_chain
    import caltime_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);
    logic cy_min, cy_hour, cy_day, cy_mon, cy_year, cy_cent;
    logic [4:0] mlen;

    always_comb begin
        mlen    = month_len(cur.month, cur.year);
        cy_min  = cur.sec >= 6'd59;
        cy_hour = cy_min  && (cur.min >= 6'd59);
        cy_day  = cy_hour && (cur.hour >= 5'd23);
        cy_mon  = cy_day  && (cur.mday >= mlen);
        cy_year = cy_mon  && (cur.month >= 4'd12);
        cy_cent = cy_year && (cur.year >= 7'd99);

        nxt      = cur;
        nxt.sec  = cy_min ? 6'd0 : cur.sec + 6'd1;
        if (cy_min)
            nxt.min = (cur.min >= 6'd59) ? 6'd0 : cur.min + 6'd1;
        if (cy_hour)
            nxt.hour = (cur.hour >= 5'd23) ? 5'd0 : cur.hour + 5'd1;
        if (cy_day) begin
            nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
            nxt.mday = (cur.mday >= mlen) ? 5'd1 : cur.mday + 5'd1;
        end
        if (cy_mon)
            nxt.month = (cur.month >= 4'd12) ? 4'd1 : cur.month + 4'd1;
        if (cy_year)
            nxt.year = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
        if (cy_cent)
            nxt.cent = (cur.cent >= 7'd99) ? 7'd0 : cur.cent + 7'd1;
    end
endmodule

// File: rtl/caltime_codec.sv
module caltime_codec
    import caltime_pkg::*;
(
    input  cal_t              cal,
    input  logic              freeze,
    input  logic              bin,
    input  logic              h24,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [6:0]        wr_val,
    output logic              wr_ok
);
    logic [7:0] mask, masked, dec, hr_enc;
    logic [4:0] h12;

    // Read side
    always_comb begin
        h12    = (cal.hour == 5'd0)  ? 5'd12 :
                 (cal.hour > 5'd12)  ? cal.hour - 5'd12 : cal.hour;
        hr_enc = h24 ? encode({2'b0, cal.hour}, bin)
                     : {cal.hour >= 5'd12, 7'(encode({2'b0, h12}, bin))};
        case (rd_addr)
            A_SEC:   rd_data = encode({1'b0, cal.sec}, bin);
            A_MIN:   rd_data = encode({1'b0, cal.min}, bin);
            A_HOUR:  rd_data = hr_enc;
            A_WDAY:  rd_data = encode({4'b0, cal.wday}, bin);
            A_MDAY:  rd_data = encode({2'b0, cal.mday}, bin);
            A_MON:   rd_data = encode({3'b0, cal.month}, bin);
            A_YEAR:  rd_data = encode(cal.year, bin);
            A_CENT:  rd_data = encode(cal.cent, bin);
            A_CTL:   rd_data = {freeze, 4'b0, bin, h24, 1'b0};
            default: rd_data = '0;
        endcase
    end

    // Write side: mask, decode, range check
    always_comb begin
        case (wr_addr)
            A_SEC, A_MIN: mask = bin ? 8'h3F : 8'h7F;
            A_HOUR:       mask = h24 ? (bin ? 8'h1F : 8'h3F) : (bin ? 8'h0F : 8'h1F);
            A_WDAY:       mask = 8'h07;
            A_MDAY:       mask = bin ? 8'h1F : 8'h3F;
            A_MON:        mask = bin ? 8'h0F : 8'h1F;
            A_YEAR:       mask = bin ? 8'h7F : 8'hFF;
            default:      mask = 8'hFF;
        endcase
        masked = wr_data & mask;
        dec    = bin ? masked : from_bcd(masked);
        wr_val = dec[6:0];
        wr_ok  = 1'b0;
        case (wr_addr)
            A_SEC, A_MIN:   wr_ok = dec <= 8'd59;
            A_HOUR: begin
                if (h24) begin
                    wr_ok = dec <= 8'd23;
                end else begin
                    wr_ok  = (dec >= 8'd1) && (dec <= 8'd12);
                    wr_val = 7'((dec == 8'd12) ? 8'd0 : dec) + (wr_data[7] ? 7'd12 : 7'd0);
                end
            end
            A_WDAY:         wr_ok = (dec >= 8'd1) && (dec <= 8'd7);
            A_MDAY:         wr_ok = (dec >= 8'd1) && (dec <= 8'd31);
            A_MON:          wr_ok = (dec >= 8'd1) && (dec <= 8'd12);
            A_YEAR, A_CENT: wr_ok = dec <= 8'd99;
            default:        wr_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/caltime_counter.sv
module caltime_counter
    import caltime_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    cal_t       cal_q, cal_nxt;
    logic       ctl_freeze, ctl_bin, ctl_h24;
    logic [6:0] wr_val;
    logic       wr_ok, fld_wr;

    caltime_strobe u_strobe (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .freeze (ctl_freeze),
        .busy   (busy)
    );

    caltime_chain u_chain (
        .cur (cal_q),
        .nxt (cal_nxt)
    );

    caltime_codec u_codec (
        .cal     (cal_q),
        .freeze  (ctl_freeze),
        .bin     (ctl_bin),
        .h24     (ctl_h24),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_val  (wr_val),
        .wr_ok   (wr_ok)
    );

    assign fld_wr = wr_en && ctl_freeze && wr_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_freeze <= 1'b0;
            ctl_bin    <= 1'b0;
            ctl_h24    <= 1'b1;
        end else if (wr_en && wr_addr == A_CTL) begin
            ctl_freeze <= wr_data[CB_FREEZE];
            ctl_bin    <= wr_data[CB_BIN];
            ctl_h24    <= wr_data[CB_H24];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q <= RESET_CAL;
        end else if (fld_wr) begin
            case (wr_addr)
                A_SEC:   cal_q.sec   <= wr_val[5:0];
                A_MIN:   cal_q.min   <= wr_val[5:0];
                A_HOUR:  cal_q.hour  <= wr_val[4:0];
                A_WDAY:  cal_q.wday  <= wr_val[2:0];
                A_MDAY:  cal_q.mday  <= wr_val[4:0];
                A_MON:   cal_q.month <= wr_val[3:0];
                A_YEAR:  cal_q.year  <= wr_val;
                A_CENT:  cal_q.cent  <= wr_val;
                default: cal_q <= cal_q;
            endcase
        end else if (busy && !ctl_freeze) begin
            cal_q <= cal_nxt;
        end
    end
endmodule

// File: rtl/caltime_chk.sv
module caltime_chk
    import caltime_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic tick,
    input logic busy,
    input logic freeze,
    input logic wr_en,
    input cal_t cal
);
    AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (rst)
        cal.sec <= 6'd59 && cal.min <= 6'd59 && cal.hour <= 5'd23 &&
        cal.wday >= 3'd1 && cal.mday >= 5'd1 && cal.month >= 4'd1 &&
        cal.month <= 4'd12 && cal.year <= 7'd99 && cal.cent <= 7'd99); // R8

    AST_TICK_BUSY: assert property (@(posedge clk) disable iff (rst)
        tick && !freeze |=> busy); // R9

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        freeze && !wr_en |=> $stable(cal)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !freeze && !busy |=> $stable(cal)); // R7

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
        busy && !freeze && cal.sec != 6'd59 |=> cal.sec == $past(cal.sec) + 6'd1); // R2

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        busy && !freeze && cal.sec == 6'd59 |=> cal.sec == 6'd0 && cal.min != $past(cal.min)); // R2
endmodule

bind caltime_counter caltime_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .busy   (busy),
    .freeze (ctl_freeze),
    .wr_en  (wr_en),
    .cal    (cal_q)
);

// File: tb/caltime_counter_test.sv
module caltime_counter_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    caltime_counter uut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        #1;
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rd_data, exp);
        end
    endtask

    task automatic chk_busy(input logic exp, input string tag);
        total++;
        if (busy !== exp) begin
            bad++;
            $display("FAIL %s busy actual=%b expected=%b", tag, busy, exp);
        end
    endtask

    // tick pulse; during the busy cycle the seconds still show old_sec (R9)
    task automatic pulse(input logic exp_busy, input logic [7:0] old_sec);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk_busy(exp_busy, "R9 busy cycle");
        chk(4'd0, old_sec, "R9 old value during busy");
        @(negedge clk);
        chk_busy(1'b0, "R9 busy one cycle");
    endtask

    task automatic t_reset;
        chk(4'd0, 8'h00, "R1 sec");
        chk(4'd1, 8'h00, "R1 min");
        chk(4'd2, 8'h00, "R1 hour");
        chk(4'd3, 8'h01, "R1 wday");
        chk(4'd4, 8'h01, "R1 mday");
        chk(4'd5, 8'h01, "R1 month");
        chk(4'd6, 8'h00, "R1 year");
        chk(4'd7, 8'h00, "R1 cent");
        chk(4'd8, 8'h02, "R1 R10 control");
        chk(4'd12, 8'h00, "R10 unmapped");
        chk_busy(1'b0, "R1 busy");
    endtask

    task automatic t_rollover;
        wr(4'd8, 8'h82);
        wr(4'd0, 8'h58); wr(4'd1, 8'h59); wr(4'd2, 8'h23); wr(4'd3, 8'h07);
        wr(4'd4, 8'h31); wr(4'd5, 8'h12); wr(4'd6, 8'h99); wr(4'd7, 8'h99);
        wr(4'd8, 8'h02);
        pulse(1'b1, 8'h58);
        chk(4'd0, 8'h59, "R2 sec step");
        chk(4'd1, 8'h59, "R2 min held");
        pulse(1'b1, 8'h59);
        chk(4'd0, 8'h00, "R2 sec wrap");
        chk(4'd1, 8'h00, "R2 min wrap");
        chk(4'd2, 8'h00, "R2 hour wrap");
        chk(4'd3, 8'h01, "R3 wday wrap");
        chk(4'd4, 8'h01, "R3 mday wrap");
        chk(4'd5, 8'h01, "R3 month wrap");
        chk(4'd6, 8'h00, "R4 year wrap");
        chk(4'd7, 8'h00, "R4 century wrap");
    endtask

    task automatic eod(input logic [7:0] md, input logic [7:0] mo, input logic [7:0] yr,
                       input logic [7:0] exp_md, input logic [7:0] exp_mo);
        wr(4'd8, 8'h82);
        wr(4'd2, 8'h23); wr(4'd1, 8'h59); wr(4'd0, 8'h59);
        wr(4'd5, mo); wr(4'd4, md); wr(4'd6, yr);
        wr(4'd8, 8'h02);
        pulse(1'b1, 8'h59);
        chk(4'd4, exp_md, "R3 month length mday");
        chk(4'd5, exp_mo, "R3 month length month");
    endtask

    task automatic t_months;
        eod(8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
        eod(8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
        eod(8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
        eod(8'h30, 8'h04, 8'h23, 8'h01, 8'h05);
        eod(8'h30, 8'h05, 8'h23, 8'h31, 8'h05);
    endtask

    task automatic t_binary;
        wr(4'd8, 8'h86);
        wr(4'd0, 8'h2D);
        chk(4'd0, 8'h2D, "R5 binary read");
        wr(4'd6, 8'h63);
        wr(4'd8, 8'h82);
        chk(4'd0, 8'h45, "R5 bcd view of binary write");
        chk(4'd6, 8'h99, "R5 bcd year");
    endtask

    task automatic t_12h;
        wr(4'd8, 8'h80);
        wr(4'd2, 8'h91);
        chk(4'd2, 8'h91, "R6 11PM readback");
        wr(4'd1, 8'h59); wr(4'd0, 8'h59);
        wr(4'd8, 8'h00);
        pulse(1'b1, 8'h59);
        chk(4'd2, 8'h12, "R6 11PM to 12AM");
        wr(4'd8, 8'h80); wr(4'd1, 8'h59); wr(4'd0, 8'h59); wr(4'd8, 8'h00);
        pulse(1'b1, 8'h59);
        chk(4'd2, 8'h01, "R6 12AM to 1AM");
        wr(4'd8, 8'h80); wr(4'd2, 8'h11); wr(4'd1, 8'h59); wr(4'd0, 8'h59); wr(4'd8, 8'h00);
        pulse(1'b1, 8'h59);
        chk(4'd2, 8'h92, "R6 11AM to 12PM");
        wr(4'd8, 8'h82);
        chk(4'd2, 8'h12, "R6 24h view of noon");
    endtask

    task automatic t_set;
        wr(4'd8, 8'h82); wr(4'd0, 8'h10); wr(4'd8, 8'h02);
        chk(4'd0, 8'h10, "R7 loaded");
        wr(4'd0, 8'h33);
        chk(4'd0, 8'h10, "R7 write blocked while running");
        wr(4'd8, 8'h82);
        pulse(1'b0, 8'h10);
        chk(4'd0, 8'h10, "R7 tick ignored while frozen");
        wr(4'd0, 8'h33);
        chk(4'd0, 8'h33, "R7 write taken while frozen");
    endtask

    task automatic t_mask;
        wr(4'd8, 8'h82);
        wr(4'd0, 8'hC5);
        chk(4'd0, 8'h45, "R8 bcd sec mask");
        wr(4'd0, 8'h60);
        chk(4'd0, 8'h45, "R8 bcd sec out of range");
        wr(4'd2, 8'h07); wr(4'd2, 8'h24);
        chk(4'd2, 8'h07, "R8 hour 24 out of range");
        wr(4'd3, 8'h05); wr(4'd3, 8'h00);
        chk(4'd3, 8'h05, "R8 wday zero");
        wr(4'd8, 8'h86);
        wr(4'd1, 8'hCA);
        chk(4'd1, 8'h0A, "R8 binary min mask");
        wr(4'd1, 8'h3C);
        chk(4'd1, 8'h0A, "R8 binary min out of range");
        wr(4'd8, 8'h80);
        wr(4'd2, 8'h13);
        chk(4'd2, 8'h07, "R8 12h hour 13");
        wr(4'd2, 8'h00);
        chk(4'd2, 8'h07, "R8 12h hour 0");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rollover();
        t_months();
        t_binary();
        t_12h();
        t_set();
        t_mask();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule